// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Controller

This block is the slave side of a small byte-addressed serial EEPROM on a two-wire bus. SCL and SDA are sampled by a faster system clock. The slave pulls SDA low through an open-drain enable, `sda_oe_o`. The memory is a register array of 2^`MEM_AW` bytes. Set `MEM_AW` to 7 for 128 bytes, 8 for 256 bytes, or 9 for 512 bytes. In the 512-byte variant, one bit of the select byte chooses the upper or lower half of the memory.

A write transaction has three parts: a select byte, one word-address byte, and one or more data bytes. The data bytes go into an 8-entry page buffer. The buffer is written into memory only when the master sends STOP. After a commit, a fixed busy count stands in for the nonvolatile write time, and during it the slave ignores its select byte. A select byte with the read bit set returns the byte at the current address.

Top module: `eeprom_slave`

## Requirements
- R1: After reset, `sda_oe_o` is low and every memory byte reads 0xFF.
- R2: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. Either one releases SDA and ends any transfer in progress.
- R3: The select byte is acknowledged only under all of these conditions:
  - bits [7:4] are 1010;
  - bits [3:1] equal `strap_i[2:0]`, except that bit 1 is not compared when `MEM_AW` is 9;
  - the busy count is zero.
  On a mismatch the slave leaves SDA alone until the next START. Bit 0 of the select byte is R/W, with 1 meaning read.
- R4: The slave drives an ACK from the eighth SCL falling edge of a byte until the ninth falling edge, and releases it afterwards. `sda_oe_o` changes only while SCL is low.
- R5: In a byte write, the select byte (R/W=0), the word-address byte and the data byte are each acknowledged. When `MEM_AW` is 7, bit 7 of the word-address byte is ignored.
- R6: Data written into the page buffer reaches memory only on STOP. A repeated START before STOP discards the buffered data.
- R7: In a page write, the three low address bits advance after each data byte and wrap within the 8-byte page, while the upper bits stay fixed. A ninth or later byte overwrites the buffer entry at its offset.
- R8: While `wp_i` is high at STOP, address and data bytes are still acknowledged. Memory is left unchanged and no busy count starts.
- R9: A commit starts a busy count of `BUSY_CYC` system cycles. During the count the slave acknowledges no select byte.
- R10: When `MEM_AW` is 9, select bit 1 becomes memory address bit 8, for both writes and reads.
- R11: A read returns the byte at the current address, MSB first, with each bit changing after an SCL falling edge. The slave releases SDA for the master's acknowledge slot. The current address then advances by one and wraps over the whole memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line, asynchronous to `clk_i` |
| sda_i | input | 1 | Bus data line as seen on the wire |
| strap_i | input | 3 | Device select straps |
| wp_i | input | 1 | Write protect; high suppresses commits |
| sda_oe_o | output | 1 | High pulls SDA low |

## Verification
Most faults in the internal state appear as a wrong ACK bit within the same byte. Examples are a wrong bit count, a wrong select decode, or a busy count that never clears. A corrupted word address or page offset cannot be seen at the bus until a later read returns a wrong byte. For that reason every write is followed by reads of the whole affected page and of its neighbour. A commit that fires on the wrong event shows up in one of two ways: as stale 0xFF data after a restart, or as a NACK on the next select byte.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WADDR,
    ST_WDATA,
    ST_RDATA
  } bus_state_e;

  localparam logic [3:0] DEV_CODE = 4'b1010;
endpackage

// File: rtl/eeprom_bus_sync.sv
module eeprom_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  // [STAGES-1] is the synchronized value, [STAGES] its previous sample
  logic [STAGES:0] scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[STAGES-1:0], scl_i};
      sda_q <= {sda_q[STAGES-1:0], sda_i};
    end
  end

  logic scl_now, scl_prev, sda_now, sda_prev;
  assign scl_now  = scl_q[STAGES-1];
  assign scl_prev = scl_q[STAGES];
  assign sda_now  = sda_q[STAGES-1];
  assign sda_prev = sda_q[STAGES];

  assign sda_o      = sda_now;
  assign scl_rise_o = scl_now & ~scl_prev;
  assign scl_fall_o = ~scl_now & scl_prev;
  assign start_o    = scl_now & scl_prev & sda_prev & ~sda_now;
  assign stop_o     = scl_now & scl_prev & ~sda_prev & sda_now;
endmodule

// File: rtl/eeprom_page_buf.sv
module eeprom_page_buf #(
  parameter int PAGE_AW = 3
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              clr_i,
  input  logic                              wr_i,
  input  logic [PAGE_AW-1:0]                off_i,
  input  logic [7:0]                        data_i,
  output logic [(1<<PAGE_AW)-1:0]           valid_o,
  output logic [(1<<PAGE_AW)-1:0][7:0]      data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= '0;
      data_o  <= '0;
    end else if (clr_i) begin
      valid_o <= '0;
    end else if (wr_i) begin
      valid_o[off_i] <= 1'b1;
      data_o[off_i]  <= data_i;
    end
  end
endmodule

// File: rtl/eeprom_mem_array.sv
module eeprom_mem_array #(
  parameter int AW      = 7,
  parameter int PAGE_AW = 3
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         commit_i,
  input  logic [AW-PAGE_AW-1:0]        page_i,
  input  logic [(1<<PAGE_AW)-1:0]      valid_i,
  input  logic [(1<<PAGE_AW)-1:0][7:0] data_i,
  input  logic [AW-1:0]                rd_addr_i,
  output logic [7:0]                   rd_data_o
);
  localparam int WORDS = 1 << AW;
  localparam int PAGE  = 1 << PAGE_AW;

  logic [7:0] mem_q [WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < WORDS; w++) mem_q[w] <= 8'hFF;
    end else if (commit_i) begin
      for (int o = 0; o < PAGE; o++)
        if (valid_i[o]) mem_q[{page_i, o[PAGE_AW-1:0]}] <= data_i[o];
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/eeprom_slave.sv
module eeprom_slave
  import eeprom_pkg::*;
#(
  parameter int MEM_AW   = 7,
  parameter int PAGE_AW  = 3,
  parameter int BUSY_CYC = 200
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  input  logic       wp_i,
  output logic       sda_oe_o
);
  localparam int  WA_W     = (MEM_AW > 8) ? 8 : MEM_AW;
  localparam bit  PAGE_SEL = (MEM_AW > 8);
  localparam int  PAGE     = 1 << PAGE_AW;
  localparam int  BUSY_W   = $clog2(BUSY_CYC + 1);

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;

  eeprom_bus_sync #(.STAGES(2)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  bus_state_e            state_q;
  logic [3:0]            bit_cnt_q;
  logic [7:0]            shreg_q;
  logic                  oe_q;
  logic [MEM_AW-1:0]     addr_q;
  logic [BUSY_W-1:0]     busy_q;
  logic                  busy_act;
  logic                  byte_done, sel_ok, buf_clr, buf_wr, commit;
  logic [PAGE-1:0]       buf_valid;
  logic [PAGE-1:0][7:0]  buf_data;
  logic [7:0]            rd_data;

  assign busy_act  = (busy_q != '0);
  assign byte_done = scl_fall && (bit_cnt_q == 4'd8);
  assign buf_clr   = byte_done && (state_q == ST_WADDR);
  assign buf_wr    = byte_done && (state_q == ST_WDATA);
  assign commit    = stop_det && (state_q == ST_WDATA) && (|buf_valid) && !wp_i;

  always_comb begin
    sel_ok = (shreg_q[7:4] == DEV_CODE) && (shreg_q[3:2] == strap_i[2:1]) && !busy_act;
    if (!PAGE_SEL) sel_ok = sel_ok && (shreg_q[1] == strap_i[0]);
  end

  eeprom_page_buf #(.PAGE_AW(PAGE_AW)) u_buf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (buf_clr),
    .wr_i    (buf_wr),
    .off_i   (addr_q[PAGE_AW-1:0]),
    .data_i  (shreg_q),
    .valid_o (buf_valid),
    .data_o  (buf_data)
  );

  eeprom_mem_array #(.AW(MEM_AW), .PAGE_AW(PAGE_AW)) u_mem (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .commit_i  (commit),
    .page_i    (addr_q[MEM_AW-1:PAGE_AW]),
    .valid_i   (buf_valid),
    .data_i    (buf_data),
    .rd_addr_i (addr_q),
    .rd_data_o (rd_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      shreg_q   <= '0;
      oe_q      <= 1'b0;
      addr_q    <= '0;
      busy_q    <= '0;
    end else begin
      if (busy_act) busy_q <= busy_q - BUSY_W'(1);
      if (start_det) begin
        state_q   <= ST_DEV;
        bit_cnt_q <= '0;
        oe_q      <= 1'b0;
      end else if (stop_det) begin
        state_q <= ST_IDLE;
        oe_q    <= 1'b0;
        if (commit) busy_q <= BUSY_W'(BUSY_CYC);
      end else begin
        unique case (state_q)
          ST_DEV, ST_WADDR, ST_WDATA: begin
            if (scl_rise && bit_cnt_q < 4'd8) begin
              shreg_q   <= {shreg_q[6:0], sda_s};
              bit_cnt_q <= bit_cnt_q + 4'd1;
            end else if (byte_done) begin
              bit_cnt_q <= 4'd9;
              if (state_q == ST_DEV) begin
                if (sel_ok) begin
                  oe_q    <= 1'b1;
                  state_q <= shreg_q[0] ? ST_RDATA : ST_WADDR;
                  if (PAGE_SEL) addr_q[MEM_AW-1] <= shreg_q[1];
                end else begin
                  state_q <= ST_IDLE;
                end
              end else begin
                oe_q <= 1'b1;
                if (state_q == ST_WADDR) begin
                  addr_q[WA_W-1:0] <= shreg_q[WA_W-1:0];
                  state_q          <= ST_WDATA;
                end else begin
                  addr_q[PAGE_AW-1:0] <= addr_q[PAGE_AW-1:0] + PAGE_AW'(1);
                end
              end
            end else if (scl_fall && bit_cnt_q == 4'd9) begin
              oe_q      <= 1'b0;
              bit_cnt_q <= '0;
            end
          end
          ST_RDATA: begin
            if (scl_fall) begin
              if (bit_cnt_q == 4'd9) begin
                // ack slot of the select byte ends: present MSB
                shreg_q   <= rd_data;
                oe_q      <= ~rd_data[7];
                bit_cnt_q <= '0;
                addr_q    <= addr_q + MEM_AW'(1);
              end else if (bit_cnt_q < 4'd7) begin
                shreg_q   <= {shreg_q[6:0], 1'b0};
                oe_q      <= ~shreg_q[6];
                bit_cnt_q <= bit_cnt_q + 4'd1;
              end else if (bit_cnt_q == 4'd7) begin
                oe_q      <= 1'b0;
                bit_cnt_q <= 4'd8;
              end else begin
                state_q   <= ST_IDLE;
                bit_cnt_q <= '0;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o = oe_q;
endmodule

// File: rtl/eeprom_slave_chk.sv
module eeprom_slave_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_i,
  input logic sda_oe_o,
  input logic wp_i,
  input logic start_det,
  input logic stop_det,
  input logic busy_act
);
  // R4
  oe_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_i);

  // R2
  start_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> !sda_oe_o);

  // R2
  stop_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> !sda_oe_o);

  // R9
  busy_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_act |-> !sda_oe_o);

  // R8
  busy_origin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_act) |-> ($past(stop_det) && !$past(wp_i)));
endmodule

bind eeprom_slave eeprom_slave_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .scl_i     (scl_i),
  .sda_oe_o  (sda_oe_o),
  .wp_i      (wp_i),
  .start_det (start_det),
  .stop_det  (stop_det),
  .busy_act  (busy_act)
);

// File: tb/eeprom_slave_bench.sv
`timescale 1ns/1ps
module eeprom_slave_bench;
  localparam int Q    = 8;
  localparam int BUSY = 240;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic wp = 1'b0;
  logic oe_a, oe_b;
  logic sda_bus;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [7:0] pd [16];
  logic [7:0] mdl [8];

  always #2 clk = ~clk;
  assign sda_bus = sda_m & ~oe_a & ~oe_b;

  // 128-byte slave, straps 010 -> select 0xA4/0xA5
  eeprom_slave #(.MEM_AW(7), .BUSY_CYC(BUSY)) u_eeprom_slave (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(scl_m), .sda_i(sda_bus),
    .strap_i(3'b010), .wp_i(wp), .sda_oe_o(oe_a));

  // 512-byte slave, straps 10x -> select 0xA8..0xAB, bit1 = page
  eeprom_slave #(.MEM_AW(9), .BUSY_CYC(BUSY)) u_eeprom_slave_pg (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(scl_m), .sda_i(sda_bus),
    .strap_i(3'b101), .wp_i(wp), .sda_oe_o(oe_b));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic half();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; half(); scl_m = 1'b1; half(); sda_m = 1'b0; half(); scl_m = 1'b0; half();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; half(); scl_m = 1'b1; half(); sda_m = 1'b1; half();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; half(); scl_m = 1'b1; half(); scl_m = 1'b0;
    end
    sda_m = 1'b1; half(); scl_m = 1'b1; half(); ack = ~sda_bus; scl_m = 1'b0;
  endtask

  task automatic recv_byte(output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; half(); scl_m = 1'b1; half(); b[i] = sda_bus; scl_m = 1'b0;
    end
    sda_m = 1'b1; half(); scl_m = 1'b1; half(); scl_m = 1'b0;  // master NACK
  endtask

  task automatic wr_seq(input logic [7:0] sel, input logic [7:0] wa, input int n,
                        input bit do_stop, output bit ok);
    bit a;
    ok = 1'b1;
    bus_start();
    send_byte(sel, a); ok &= a;
    send_byte(wa, a);  ok &= a;
    for (int i = 0; i < n; i++) begin send_byte(pd[i], a); ok &= a; end
    if (do_stop) bus_stop();
  endtask

  task automatic read_at(input logic [7:0] sel, input logic [7:0] wa, output logic [7:0] d);
    bit a;
    bus_start(); send_byte(sel, a); send_byte(wa, a);
    bus_start(); send_byte(sel | 8'h01, a); recv_byte(d); bus_stop();
  endtask

  task automatic read_cur(input logic [7:0] sel, output logic [7:0] d);
    bit a;
    bus_start(); send_byte(sel | 8'h01, a); recv_byte(d); bus_stop();
  endtask

  task automatic settle();
    repeat (BUSY + 20) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    bit a, ok;
    logic [7:0] d;
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    chk("R1 oe_a after reset", oe_a, 0);
    chk("R1 oe_b after reset", oe_b, 0);
    read_at(8'hA4, 8'h33, d);
    chk("R1 erased byte", d, 8'hFF);

    // R3 sweep of every write select byte
    for (int b = 0; b < 256; b += 2) begin
      bus_start(); send_byte(b[7:0], a); bus_stop();
      chk("R3 select sweep", a, (b[7:1] == 7'b1010010) || (b[7:2] == 6'b101010));
    end

    // R3 after a mismatch a matching pattern is ignored until START
    bus_start(); send_byte(8'hA0, a); chk("R3 mismatch nack", a, 0);
    send_byte(8'hA4, a); chk("R3 ignored until start", a, 0);
    bus_stop();

    // R4 ACK released after ninth clock
    bus_start(); send_byte(8'hA4, a); chk("R4 ack driven", a, 1);
    half(); chk("R4 ack released", sda_bus, 1);
    bus_stop();

    // R5 byte write, address MSB ignored on 7-bit part; R9 busy
    pd[0] = 8'h3C;
    wr_seq(8'hA4, 8'h85, 1, 1'b1, ok);
    chk("R5 byte write acks", ok, 1);
    bus_start(); send_byte(8'hA4, a); bus_stop();
    chk("R9 busy nack", a, 0);
    settle();
    bus_start(); send_byte(8'hA4, a); bus_stop();
    chk("R9 ack after busy", a, 1);
    pd[0] = 8'hA7; wr_seq(8'hA4, 8'h06, 1, 1'b1, ok); settle();
    pd[0] = 8'h11; wr_seq(8'hA4, 8'h7F, 1, 1'b1, ok); settle();
    pd[0] = 8'h22; wr_seq(8'hA4, 8'h00, 1, 1'b1, ok); settle();

    read_at(8'hA4, 8'h05, d); chk("R5 data at 0x05", d, 8'h3C);
    // R11 current-address reads advance
    read_cur(8'hA4, d); chk("R11 next address", d, 8'hA7);
    read_cur(8'hA4, d); chk("R11 second advance", d, 8'hFF);
    read_at(8'hA4, 8'h7F, d); chk("R11 last byte", d, 8'h11);
    read_cur(8'hA4, d); chk("R11 wrap to zero", d, 8'h22);

    // R6 repeated START discards buffered data
    pd[0] = 8'h99;
    wr_seq(8'hA4, 8'h40, 1, 1'b0, ok);
    read_at(8'hA4, 8'h40, d);
    chk("R6 no commit without stop", d, 8'hFF);

    // R7 page write of 10 bytes from offset 3
    for (int i = 0; i < 8; i++) mdl[i] = 8'hFF;
    for (int i = 0; i < 10; i++) begin
      pd[i] = 8'h80 + 8'(i);
      mdl[(3 + i) % 8] = pd[i];
    end
    wr_seq(8'hA4, 8'h13, 10, 1'b1, ok);
    chk("R7 page acks", ok, 1);
    settle();
    for (int i = 0; i < 8; i++) begin
      read_at(8'hA4, 8'h10 + 8'(i), d);
      chk("R7 page content", d, mdl[i]);
    end
    read_at(8'hA4, 8'h18, d); chk("R7 next page untouched", d, 8'hFF);
    read_at(8'hA4, 8'h0F, d); chk("R7 prior page untouched", d, 8'hFF);

    // R8 write protect
    wp = 1'b1;
    pd[0] = 8'h77; pd[1] = 8'h78;
    wr_seq(8'hA4, 8'h50, 2, 1'b1, ok);
    chk("R8 acks under protect", ok, 1);
    bus_start(); send_byte(8'hA4, a); bus_stop();
    chk("R8 no busy", a, 1);
    wp = 1'b0;
    read_at(8'hA4, 8'h50, d); chk("R8 memory unchanged", d, 8'hFF);
    read_at(8'hA4, 8'h51, d); chk("R8 memory unchanged +1", d, 8'hFF);

    // R10 page select on 512-byte part
    pd[0] = 8'h0F; wr_seq(8'hA8, 8'h20, 1, 1'b1, ok); settle();
    pd[0] = 8'hF0; wr_seq(8'hAA, 8'h20, 1, 1'b1, ok); settle();
    read_at(8'hA8, 8'h20, d); chk("R10 lower half", d, 8'h0F);
    read_at(8'hAA, 8'h20, d); chk("R10 upper half", d, 8'hF0);
    read_cur(8'hAA, d); chk("R10 R11 upper half advance", d, 8'hFF);
    read_at(8'hA4, 8'h20, d); chk("R3 other slave untouched", d, 8'hFF);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule